// File: doc/BRIEF.md
# Four-Lane 7:1 Serial Link Transmitter

This block turns a wide parallel word into a narrow serial link. Once per word period it samples a 28-bit word and sends it as four serial data lanes, each carrying seven bits, together with a fifth lane that repeats the word clock so that a receiver can recover the framing. A bit clock running at seven times the word rate, phase-aligned to the word clock, stands in for the frequency-multiplying loop of a physical transmitter. The word clock is treated as a level signal sampled by the bit clock, and the bit-clock edge that sees it rise marks the start of a word.

An active-low powerdown input silences every serial output and restarts a lock interval. After powerdown is released, the block counts a configurable number of word starts before it drives its outputs. It then raises an output-enable flag, which models the tri-state control of the line drivers and also tells the rest of the system that the link is ready. Each word reaches the serial lanes one word period after it was sampled.

Top module: `serlink7_tx`

## Requirements
- R1: A word start is the bit-clock rising edge at which `wordClk` is high and was low at the previous bit-clock edge. All 28 bits of `dataIn` are captured at that edge.
- R2: Lane k (`serData[k]`, k = 0..3) carries input bits 7k to 7k+6, least significant first, one bit per bit-clock cycle. Bit 0 is driven for the bit-clock cycle that follows a word-start edge, and slot s for the s-th cycle after that.
- R3: The word captured at one word start is the word serialized during the next word period, a latency of exactly seven bit-clock cycles.
- R4: While `outEn` is high, `serClk` is 1 in slots 0 to 3 and 0 in slots 4 to 6. This gives one rising edge per word, coincident with bit 0.
- R5: At the first bit-clock edge that sees `pwrDnN` low, `outEn`, all of `serData` and `serClk` become 0. They stay 0 while `pwrDnN` is low.
- R6: After `pwrDnN` returns high, `outEn` rises at the LOCK_WORDS-th word start seen with `pwrDnN` high, and not before. From that same edge the serial outputs begin toggling.
- R7: Any powerdown, including one lasting a single bit-clock cycle, discards lock progress. The full LOCK_WORDS word starts are then needed again.
- R8: Whenever `outEn` is 0, `serData` and `serClk` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Bit clock, seven times the word rate, phase-aligned to the word clock |
| wordClk | input | 1 | Word clock, sampled by bitClk; its rising edge frames a word |
| pwrDnN | input | 1 | Active-low powerdown; also restarts the lock interval |
| dataIn | input | 28 | Parallel word, captured at each word start |
| serData | output | 4 | Serial data lanes, one bit per bit-clock cycle |
| serClk | output | 1 | Forwarded word-rate clock lane |
| outEn | output | 1 | Link ready; models the enable of the tri-state line drivers |

## Verification
The bench runs all-zero and all-one words, then alternating 0101 and 1010 patterns that expose a slot shifted by one. It also sends single-bit words at the lowest and highest input bit, which catch reversed bit order or swapped lanes, and a word with only bit 0 of each lane set, which catches a wrong lane-to-group mapping. Irregular words back to back separate the one-word latency from a zero- or two-word latency. Each slot of every lane and of the clock lane is compared against a model of the previous word. Powerdown is applied for several words mid-frame and then as a one-cycle pulse, and the enable instant is checked cycle by cycle during both relocks.

// File: rtl/serlink7_pkg.sv
package serlink7_pkg;
  // Strobes passed from the control path to the datapath each bit cycle.
  typedef struct packed {
    logic load;      // word start: move captured word into lane shifters
    logic clear;     // powerdown: clear datapath state
    logic clkLevel;  // level of the forwarded clock for the coming slot
  } serStrobe_t;
endpackage

// File: rtl/serlink7_ctrl.sv
module serlink7_ctrl
  import serlink7_pkg::*;
#(
  parameter int unsigned LANE_BITS  = 7,
  parameter int unsigned CLK_HIGH   = 4,
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic       bitClk,
  input  logic       pwrDnN,
  input  logic       wordClk,
  output serStrobe_t strobe,
  output logic       ready
);
  localparam int unsigned SLOT_W = $clog2(LANE_BITS);
  localparam int unsigned LOCK_W = $clog2(LOCK_WORDS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANE_BITS - 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_WORDS - 1);

  logic              wordClkQ;
  logic              wordStart;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] nextSlot;
  logic [LOCK_W-1:0] lockCnt;

  // Word-clock sampler: the edge that first sees it high starts a word.
  always_ff @(posedge bitClk) begin
    wordClkQ <= wordClk;
  end

  assign wordStart = wordClk & ~wordClkQ;

  always_comb begin
    if (wordStart || slot == LAST_SLOT) begin
      nextSlot = '0;
    end else begin
      nextSlot = slot + 1'b1;
    end
  end

  always_ff @(posedge bitClk) begin
    if (!pwrDnN) begin
      slot <= '0;
    end else begin
      slot <= nextSlot;
    end
  end

  // Lock interval: count word starts after release, then hold ready.
  always_ff @(posedge bitClk) begin
    if (!pwrDnN) begin
      lockCnt <= '0;
      ready   <= 1'b0;
    end else if (wordStart && !ready) begin
      lockCnt <= lockCnt + 1'b1;
      if (lockCnt == LOCK_LAST) begin
        ready <= 1'b1;
      end
    end
  end

  assign strobe.load     = wordStart & pwrDnN;
  assign strobe.clear    = ~pwrDnN;
  assign strobe.clkLevel = (32'(nextSlot) < CLK_HIGH);
endmodule

// File: rtl/serlink7_datapath.sv
module serlink7_datapath
  import serlink7_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_BITS = 7
) (
  input  logic                       bitClk,
  input  serStrobe_t                 strobe,
  input  logic                       ready,
  input  logic [LANES*LANE_BITS-1:0] dataIn,
  output logic [LANES-1:0]           serData,
  output logic                       serClk
);
  localparam int unsigned WORD_W = LANES * LANE_BITS;

  logic [WORD_W-1:0] captured;
  logic              clkReg;

  // Capture stage: holds the word for one word period.
  always_ff @(posedge bitClk) begin
    if (strobe.clear) begin
      captured <= '0;
    end else if (strobe.load) begin
      captured <= dataIn;
    end
  end

  // One shift register per lane, LSB leaves first.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_BITS-1:0] shifter;

    always_ff @(posedge bitClk) begin
      if (strobe.clear) begin
        shifter <= '0;
      end else if (strobe.load) begin
        shifter <= captured[k*LANE_BITS +: LANE_BITS];
      end else begin
        shifter <= {1'b0, shifter[LANE_BITS-1:1]};
      end
    end

    assign serData[k] = shifter[0] & ready;
  end

  // Forwarded clock lane, registered alongside the data slots.
  always_ff @(posedge bitClk) begin
    if (strobe.clear) begin
      clkReg <= 1'b0;
    end else begin
      clkReg <= strobe.clkLevel;
    end
  end

  assign serClk = clkReg & ready;
endmodule

// File: rtl/serlink7_tx.sv
module serlink7_tx
  import serlink7_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LANE_BITS  = 7,
  parameter int unsigned CLK_HIGH   = 4,
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic                       bitClk,
  input  logic                       wordClk,
  input  logic                       pwrDnN,
  input  logic [LANES*LANE_BITS-1:0] dataIn,
  output logic [LANES-1:0]           serData,
  output logic                       serClk,
  output logic                       outEn
);
  serStrobe_t strobe;
  logic       ready;

  serlink7_ctrl #(
    .LANE_BITS (LANE_BITS),
    .CLK_HIGH  (CLK_HIGH),
    .LOCK_WORDS(LOCK_WORDS)
  ) u_ctrl (
    .bitClk (bitClk),
    .pwrDnN (pwrDnN),
    .wordClk(wordClk),
    .strobe (strobe),
    .ready  (ready)
  );

  serlink7_datapath #(
    .LANES    (LANES),
    .LANE_BITS(LANE_BITS)
  ) u_dp (
    .bitClk (bitClk),
    .strobe (strobe),
    .ready  (ready),
    .dataIn (dataIn),
    .serData(serData),
    .serClk (serClk)
  );

  assign outEn = ready;
endmodule

// File: rtl/serlink7_tx_chk.sv
module serlink7_tx_chk #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_BITS = 7,
  parameter int unsigned CLK_HIGH  = 4
) (
  input logic                       bitClk,
  input logic                       wordClk,
  input logic                       pwrDnN,
  input logic [LANES*LANE_BITS-1:0] dataIn,
  input logic [LANES-1:0]           serData,
  input logic                       serClk,
  input logic                       outEn
);
  localparam int unsigned WORD_W = LANES * LANE_BITS;

  logic              armed = 1'b0;
  logic              ckWcQ;
  logic [WORD_W-1:0] ckLast;
  logic [WORD_W-1:0] ckSend;
  logic [7:0]        hiRun;
  logic [LANES-1:0]  slot0Exp;

  always_ff @(posedge bitClk) begin
    armed <= 1'b1;
    ckWcQ <= wordClk;
  end

  // Independent two-word shadow of the input stream.
  always_ff @(posedge bitClk) begin
    if (!pwrDnN) begin
      ckLast <= '0;
      ckSend <= '0;
    end else if (wordClk && !ckWcQ) begin
      ckLast <= dataIn;
      ckSend <= ckLast;
    end
  end

  always_ff @(posedge bitClk) begin
    if (!outEn || !serClk) begin
      hiRun <= '0;
    end else begin
      hiRun <= hiRun + 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      slot0Exp[k] = ckSend[k*LANE_BITS];
    end
  end

  // R8: quiet outputs whenever the enable is low
  p_quiet_when_off_r8: assert property (@(posedge bitClk) disable iff (!armed)
    !outEn |-> (serData == '0 && !serClk));

  // R5: powerdown disables the outputs by the next edge
  p_pdn_silences_r5: assert property (@(posedge bitClk) disable iff (!armed)
    !pwrDnN |=> !outEn);

  // R6: enable rises on a word boundary, with the clock lane high
  p_enable_at_start_r6: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    $rose(outEn) |-> serClk);

  // R4: clock lane high for exactly CLK_HIGH slots per word
  p_clk_high_width_r4: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    (outEn && $past(outEn) && $fell(serClk)) |-> (32'(hiRun) == CLK_HIGH));

  // R2: slot 0 of each lane is bit 0 of its group from the previous word
  p_slot0_lanes_r2: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    (outEn && $rose(serClk)) |-> (serData == slot0Exp));
endmodule

bind serlink7_tx serlink7_tx_chk #(
  .LANES    (LANES),
  .LANE_BITS(LANE_BITS),
  .CLK_HIGH (CLK_HIGH)
) u_chk (
  .bitClk (bitClk),
  .wordClk(wordClk),
  .pwrDnN (pwrDnN),
  .dataIn (dataIn),
  .serData(serData),
  .serClk (serClk),
  .outEn  (outEn)
);

// File: tb/serlink7_tx_bench.sv
`timescale 1ns/1ps
module serlink7_tx_bench;
  localparam int LANES = 4;
  localparam int LANE_BITS = 7;
  localparam int CLK_HIGH = 4;
  localparam int LOCK = 8;
  localparam int NVEC = 10;

  // Stimulus words; expected serial bits are derived per R2/R3.
  localparam logic [27:0] VEC [NVEC] = '{
    28'h0000000, 28'hFFFFFFF, 28'h5555555, 28'hAAAAAAA, 28'h0000001,
    28'h8000000, 28'h0204081, 28'hFE00000, 28'h1234567, 28'h0FEDCBA
  };

  logic        bitClk = 1'b0;
  logic        wordClk;
  logic        pwrDnN;
  logic [27:0] dataIn;
  logic [3:0]  serData;
  logic        serClk;
  logic        outEn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int          phase;
  int          startsSinceRel;
  logic [27:0] lastPresented;
  logic [27:0] sendWord;
  string       curTag;

  always #10 bitClk = ~bitClk;

  serlink7_tx #(
    .LANES(LANES), .LANE_BITS(LANE_BITS), .CLK_HIGH(CLK_HIGH), .LOCK_WORDS(LOCK)
  ) u_serlink7_tx (
    .bitClk(bitClk), .wordClk(wordClk), .pwrDnN(pwrDnN), .dataIn(dataIn),
    .serData(serData), .serClk(serClk), .outEn(outEn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Compare outputs produced by the last edge, then present the next cycle.
  task automatic step(input logic pdnNext, input logic [27:0] dNext);
    logic       expEn;
    logic [3:0] expData;
    @(negedge bitClk);
    expEn = (startsSinceRel >= LOCK);
    chk(outEn == expEn, curTag, "outEn", {31'd0, outEn}, {31'd0, expEn});
    if (expEn) begin
      for (int k = 0; k < LANES; k++) expData[k] = sendWord[k*LANE_BITS + phase];
      chk(serData == expData, "R1 R2 R3", "serData", {28'd0, serData}, {28'd0, expData});
      chk(serClk == (phase < CLK_HIGH), "R4", "serClk", {31'd0, serClk},
          {31'd0, phase < CLK_HIGH});
    end else begin
      chk(serData == 4'd0 && !serClk, "R8", "quiet outputs",
          {27'd0, serClk, serData}, 32'd0);
    end
    pwrDnN = pdnNext;
    phase = (phase == LANE_BITS - 1) ? 0 : phase + 1;
    wordClk = (phase < CLK_HIGH);
    if (phase == 0) begin
      dataIn = dNext;
      sendWord = lastPresented;
      lastPresented = dNext;
    end
    if (!pdnNext) begin
      startsSinceRel = 0;
      lastPresented = '0;
      sendWord = '0;
    end else if (phase == 0) begin
      startsSinceRel++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    pwrDnN = 1'b0;
    wordClk = 1'b0;
    dataIn = '0;
    phase = LANE_BITS - 1;
    startsSinceRel = 0;
    lastPresented = '0;
    sendWord = '0;

    // Reset state under powerdown (R5, R8)
    curTag = "R5";
    repeat (14) step(1'b0, 28'h3C3C3C3);

    // Lock interval after release, checked every cycle (R6)
    curTag = "R6";
    for (int i = 0; i < LOCK * LANE_BITS + 3; i++) step(1'b1, 28'h0ABCDEF);

    // Main stimulus table (R1, R2, R3, R4)
    curTag = "R2";
    for (int i = 0; i < NVEC; i++) begin
      repeat (LANE_BITS) step(1'b1, VEC[i]);
    end
    repeat (2 * LANE_BITS) step(1'b1, 28'h0000000);

    // Powerdown in mid-word, held for several words (R5)
    curTag = "R5";
    repeat (3) step(1'b1, 28'h1111111);
    repeat (3 * LANE_BITS) step(1'b0, 28'h2222222);

    // Full relock after a long powerdown (R7)
    curTag = "R7";
    for (int i = 0; i < (LOCK + 2) * LANE_BITS; i++) step(1'b1, 28'h7654321 ^ 28'(i));

    // Single-cycle powerdown pulse restarts the whole lock count (R7)
    repeat (4) step(1'b1, 28'h0F0F0F0);
    step(1'b0, 28'h0F0F0F0);
    for (int i = 0; i < (LOCK + 1) * LANE_BITS; i++) step(1'b1, 28'hC0FFEE1 + 28'(i));

    // Table once more after relock (R2, R3)
    curTag = "R3";
    for (int i = NVEC - 1; i >= 0; i--) begin
      repeat (LANE_BITS) step(1'b1, VEC[i]);
    end
    repeat (2 * LANE_BITS) step(1'b1, 28'h0000000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule